// File: doc/BRIEF.md
# Four-Output PWM Group Generator

This block is one group of a pulse-width modulation generator aimed at motor drives and audio power stages. A single free-running counter sets the timebase. Four outputs are derived from it by comparing the count against per-output duty thresholds. The counter either runs as a sawtooth (edge-aligned) or as a triangle (center-aligned). The outputs can be used as two complementary pairs or as four independent channels.

Software loads a period, four duty values and a mode word through a simple write port. Every write lands in a staging copy. The staged values move into the working copy only at fixed points in the waveform, so a pulse is never cut short by a write in the middle of a period. In center-aligned mode a second load point at the turn of the triangle allows the falling half of the period to use different thresholds, which gives asymmetric pulses. A one-cycle sync output marks each period start, and it also marks the turn when that second load point is in use.

Top module: `pwm_quad_group`

## Requirements
- R1: After reset the group is at the first cycle of a period in edge-aligned, paired, single-load mode, with a period of PER_RST (16) and all duties 0. In that cycle pwm_o is 4'b1010 and sync_o is 1.
- R2: The writable registers are: address 0, the mode word (bit 0 center-aligned, bit 1 independent outputs, bit 2 double load); address 1, the period; addresses 4 to 7, the duty values for output slots 0 to 3. A write changes no output before the next period start.
- R3: In edge-aligned mode a period lasts P cycles, and the count runs 0 to P-1. An output is high in the first D cycles of each period, counted from the sync cycle.
- R4: In center-aligned mode a period lasts 2P cycles. The count rises 0 to P-1 and then falls P-1 to 0, so each value appears twice. An output is high while the count is below D, which gives D high cycles at each end of the period.
- R5: In paired mode, pwm_o[0] follows duty slot 0 and pwm_o[2] follows duty slot 2. pwm_o[1] is the inverse of pwm_o[0], and pwm_o[3] is the inverse of pwm_o[2]. Duty slots 1 and 3 have no effect.
- R6: In independent mode, pwm_o[k] follows duty slot k for every k from 0 to 3.
- R7: A duty of 0 keeps its output low for the whole period. A duty of P or more keeps it high for the whole period.
- R8: sync_o is high for exactly one cycle at each period start. In center-aligned double-load mode it is also high in the first falling cycle (the turn). It is low in every other cycle.
- R9: In center-aligned single-load mode, a duty written during the rising half does not change the falling half of that period.
- R10: In center-aligned double-load mode, duty values staged before the turn apply from the first falling cycle. Period and mode changes still wait for the next period start.
- R11: A period value of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW (8) | Write data |
| sync_o | output | 1 | Period-start and turn marker |
| pwm_o | output | 4 | Modulated outputs |

## Verification
The embedded assertions watch properties that hold in every cycle:
- the count stays inside the active period;
- the count turns only at the top;
- an edge-aligned counter never falls;
- sync never stays high for two cycles when the period exceeds 1;
- the working registers change only at load points, and the turn never loads period or mode;
- paired outputs stay complementary, and a zero duty keeps its output low.

Only the directed scenarios can show the rest. These are the exact pulse widths and positions for given duties, the symmetry of the center-aligned pulses, the deferral of writes to the period boundary, and the split between rising-half and falling-half duty values in double-load mode.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  typedef struct packed {
    logic dbl_load;   // bit 2
    logic indep;      // bit 1
    logic center;     // bit 0
  } pwm_mode_t;

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_PERIOD = 3'd1;
  localparam int         NUM_OUT     = 4;

  // period value 0 runs as 1
  function automatic logic [15:0] eff_period(input logic [15:0] p);
    return (p == 16'd0) ? 16'd1 : p;
  endfunction

  // raw comparator level of one slot
  function automatic logic slot_level(input logic [15:0] cnt, input logic [15:0] duty);
    return cnt < duty;
  endfunction

  // paired: slots 0 and 2 drive a pair each, odd outputs are inverses
  function automatic logic [3:0] route_outputs(input logic [3:0] lvl, input logic indep);
    return indep ? lvl : {~lvl[2], lvl[2], ~lvl[0], lvl[0]};
  endfunction

endpackage

// File: rtl/pwm_qregs.sv
module pwm_qregs
  import pwm_quad_pkg::*;
#(
  parameter int CW      = 8,
  parameter int PER_RST = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_addr,
  input  logic [CW-1:0]              wr_data,
  input  logic                       load_full,
  input  logic                       load_turn,
  output pwm_mode_t                  act_mode,
  output logic [CW-1:0]              act_per,
  output logic [NUM_OUT-1:0][CW-1:0] act_duty
);

  pwm_mode_t                  stg_mode;
  logic [CW-1:0]              stg_per;
  logic [NUM_OUT-1:0][CW-1:0] stg_duty;

  // staging copies, written by software at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_mode <= '0;
      stg_per  <= CW'(PER_RST);
      stg_duty <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_MODE)   stg_mode <= pwm_mode_t'(wr_data[2:0]);
      if (wr_addr == ADDR_PERIOD) stg_per  <= wr_data;
      if (wr_addr[2])             stg_duty[wr_addr[1:0]] <= wr_data;
    end
  end

  // working copies, loaded only at the load points
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= '0;
      act_per  <= CW'(PER_RST);
      act_duty <= '0;
    end else if (load_full) begin
      act_mode <= stg_mode;
      act_per  <= stg_per;
      act_duty <= stg_duty;
    end else if (load_turn) begin
      act_duty <= stg_duty;
    end
  end

  assert_duty_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_full || load_turn) |=> $stable(act_duty));

  assert_turn_keeps_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_turn && !load_full) |=> ($stable(act_per) && $stable(act_mode)));

endmodule

// File: rtl/pwm_qtimebase.sv
module pwm_qtimebase
  import pwm_quad_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          center,
  input  logic          dbl_load,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic          falling,
  output logic          load_full,
  output logic          load_turn,
  output logic          sync_o
);

  logic [CW-1:0] top;
  logic          at_top;
  logic [CW-1:0] cnt_n;
  logic          falling_n;

  assign top    = CW'(eff_period(16'(per)) - 16'd1);
  assign at_top = (cnt >= top);

  always_comb begin
    cnt_n     = cnt;
    falling_n = falling;
    load_full = 1'b0;
    load_turn = 1'b0;
    if (!center) begin
      falling_n = 1'b0;
      if (at_top) begin
        cnt_n     = '0;
        load_full = 1'b1;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end else if (!falling) begin
      if (at_top) begin
        falling_n = 1'b1;
        load_turn = dbl_load;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        falling_n = 1'b0;
        load_full = 1'b1;
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      falling <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      falling <= falling_n;
    end
  end

  assign sync_o = (!falling && cnt == '0) ||
                  (center && dbl_load && falling && cnt == top);

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top);

  assert_edge_never_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !center |-> !falling);

  assert_turn_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(falling) |-> (cnt == top));

  assert_sync_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && top != '0) |=> !sync_o);

endmodule

// File: rtl/pwm_qout.sv
module pwm_qout
  import pwm_quad_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CW-1:0]              cnt,
  input  logic [NUM_OUT-1:0][CW-1:0] duty,
  input  logic                       indep,
  output logic [NUM_OUT-1:0]         pwm_o
);

  logic [NUM_OUT-1:0] lvl;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
    assign lvl[k] = slot_level(16'(cnt), 16'(duty[k]));
  end

  assign pwm_o = route_outputs(lvl, indep);

  assert_pair_inverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !indep |-> (pwm_o[1] != pwm_o[0]) && (pwm_o[3] != pwm_o[2]));

  assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty[0] == '0) |-> !pwm_o[0]);

endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
  import pwm_quad_pkg::*;
#(
  parameter int CW      = 8,
  parameter int PER_RST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          sync_o,
  output logic [3:0]    pwm_o
);

  pwm_mode_t                  act_mode;
  logic [CW-1:0]              act_per;
  logic [NUM_OUT-1:0][CW-1:0] act_duty;
  logic [CW-1:0]              cnt;
  logic                       falling;
  logic                       load_full;
  logic                       load_turn;

  pwm_qregs #(.CW(CW), .PER_RST(PER_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_full(load_full), .load_turn(load_turn),
    .act_mode(act_mode), .act_per(act_per), .act_duty(act_duty)
  );

  pwm_qtimebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n),
    .center(act_mode.center), .dbl_load(act_mode.dbl_load), .per(act_per),
    .cnt(cnt), .falling(falling),
    .load_full(load_full), .load_turn(load_turn), .sync_o(sync_o)
  );

  pwm_qout #(.CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .cnt(cnt), .duty(act_duty), .indep(act_mode.indep), .pwm_o(pwm_o)
  );

endmodule

// File: tb/sim_pwm_quad_group.sv
module sim_pwm_quad_group;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sync_o;
  logic [3:0] pwm_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pwm_quad_group u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_o(sync_o), .pwm_o(pwm_o)
  );

  // expected {sync, pwm} at phase j of a period
  function automatic logic [4:0] model(int j, int per, bit center, bit indep, bit dbl,
                                       logic [3:0][7:0] da, logic [3:0][7:0] db);
    int pe = (per == 0) ? 1 : per;
    bit dn = center && (j >= pe);
    int c  = center ? (dn ? 2 * pe - 1 - j : j) : j;
    logic [3:0][7:0] d = (dn && dbl) ? db : da;
    logic [3:0] l;
    logic [3:0] m;
    logic s;
    for (int k = 0; k < 4; k++) l[k] = (c < int'(d[k]));
    m = indep ? l : {~l[2], l[2], ~l[0], l[0]};
    s = (j == 0) || (center && dbl && j == pe);
    return {s, m};
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sync,pwm} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!sync_o && guard < 200);
  endtask

  task automatic span(string tag, int n, int j0, int per, bit center, bit indep, bit dbl,
                      logic [3:0][7:0] da, logic [3:0][7:0] db);
    int pe  = (per == 0) ? 1 : per;
    int len = center ? 2 * pe : pe;
    for (int i = 0; i < n; i++) begin
      chk(tag, {sync_o, pwm_o}, model((j0 + i) % len, per, center, indep, dbl, da, db));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", {sync_o, pwm_o}, 5'b1_1010);
    span("R1/R8", 16, 0, 16, 0, 0, 0, '0, '0);
  endtask

  task automatic t_edge_paired();
    logic [3:0][7:0] d = {8'd1, 8'd10, 8'd7, 8'd3};
    do_reset();
    wr(3'd0, 8'h00); wr(3'd1, 8'd10);
    wr(3'd4, 8'd3);  wr(3'd5, 8'd7); wr(3'd6, 8'd10); wr(3'd7, 8'd1);
    chk("R2", {sync_o, pwm_o}, model(6, 16, 0, 0, 0, '0, '0));
    wait_start();
    span("R3/R5/R7", 20, 0, 10, 0, 0, 0, d, d);
  endtask

  task automatic t_edge_indep();
    logic [3:0][7:0] d = {8'd9, 8'd5, 8'd2, 8'd0};
    do_reset();
    wr(3'd0, 8'h02); wr(3'd1, 8'd5);
    wr(3'd4, 8'd0);  wr(3'd5, 8'd2); wr(3'd6, 8'd5); wr(3'd7, 8'd9);
    wait_start();
    span("R6/R7", 10, 0, 5, 0, 1, 0, d, d);
  endtask

  task automatic t_center_single();
    logic [3:0][7:0] d0 = {8'd0, 8'd6, 8'd0, 8'd3};
    logic [3:0][7:0] d1 = {8'd0, 8'd1, 8'd0, 8'd7};
    do_reset();
    wr(3'd0, 8'h01); wr(3'd1, 8'd8); wr(3'd4, 8'd3); wr(3'd6, 8'd6);
    wait_start();
    chk("R4", {sync_o, pwm_o}, model(0, 8, 1, 0, 0, d0, d0));
    wr(3'd4, 8'd7); wr(3'd6, 8'd1);
    span("R9/R4", 14, 2, 8, 1, 0, 0, d0, d0);
    span("R2/R4", 16, 0, 8, 1, 0, 0, d1, d1);
  endtask

  task automatic t_center_double();
    logic [3:0][7:0] da = {8'd6, 8'd4, 8'd5, 8'd2};
    logic [3:0][7:0] db = {8'd1, 8'd4, 8'd5, 8'd6};
    do_reset();
    wr(3'd0, 8'h07); wr(3'd1, 8'd8);
    wr(3'd4, 8'd2);  wr(3'd5, 8'd5); wr(3'd6, 8'd4); wr(3'd7, 8'd6);
    wait_start();
    wr(3'd4, 8'd6); wr(3'd7, 8'd1); wr(3'd1, 8'd3);
    span("R10/R8", 13, 3, 8, 1, 1, 1, da, db);
    span("R10", 12, 0, 3, 1, 1, 1, db, db);
  endtask

  task automatic t_zero_period();
    logic [3:0][7:0] d = {8'd0, 8'd0, 8'd0, 8'd1};
    do_reset();
    wr(3'd0, 8'h00); wr(3'd1, 8'd0); wr(3'd4, 8'd1); wr(3'd6, 8'd0);
    wait_start();
    span("R11", 6, 0, 0, 0, 0, 0, d, d);
  endtask

  initial begin
    t_reset();
    t_edge_paired();
    t_edge_indep();
    t_center_single();
    t_center_double();
    t_zero_period();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule